// File: doc/BRIEF.md
# MMU Control Register File

This block holds the software-visible control state of an address-translation unit: a translation control word, the high and low halves of a page-table entry, a page-table assistance field, the translation-table base, the faulting address and three 11-bit event codes (trap, exception and interrupt). Software reaches them through a simple single-cycle register port. Some writes have side effects. Setting the invalidate command bit in the control word sends a one-cycle invalidate pulse to the external translation buffer. Writing a new address-space ID into the page-table-entry-high register sends a one-cycle flush pulse.

A second port decodes a 128 MB array-access window. Address bits 26:24 select one of eight sub-regions. Accesses to the four translation-buffer sub-regions are forwarded one cycle later as a request that carries the region code, the 24-bit offset, the direction and the write data. Accesses to the four cache sub-regions are absorbed: reads return zero and writes are dropped. The register port accepts only aligned long-word accesses. Any other size, a misaligned address or an undefined offset raises a one-cycle error and leaves all state unchanged.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, and no invalidate, flush, error, read-valid or forward output is asserted.
- R2: A write to the control word (offset 0x00) stores every bit except bit 2. Bit 2 always reads back 0. When bit 2 is written as 1, `tlb_invalidate` is high for exactly the one cycle after the write.
- R3: A write to page-table-entry-high (offset 0x04) stores all 32 bits. `tlb_flush` is high for the one cycle after the write only if written bits 7:0 differ from the stored bits 7:0.
- R4: The assistance register (offset 0x0C) keeps only bits 3:0. Higher written bits read back 0.
- R5: The trap (0x18), exception (0x1C) and interrupt (0x20) code registers keep only bits 10:0.
- R6: Page-table-entry-low (0x08), table base (0x10) and fault address (0x14) keep all 32 bits.
- R7: A legal read gives `reg_rvalid`=1 with the register value on `reg_rdata` in the cycle after the request. `reg_rdata` is 0 whenever `reg_rvalid` is 0.
- R8: A register access with `reg_size` other than 2 (0 byte, 1 word, 2 long-word) or with address bits 1:0 not zero raises `reg_err` for one cycle. It changes no register and produces no invalidate, flush or read-valid.
- R9: An access to an undefined offset (0x24 and above) raises `reg_err` for one cycle and changes no state.
- R10: A window access whose region code (address bits 26:24) is 2, 3, 6 or 7 produces, in the next cycle, `tlb_req_valid`=1 with that region code, address bits 23:0 as the offset, the direction and the write data.
- R11: A window access to region 0, 1, 4 or 5 produces no forward request. A write there has no other effect, and a read returns `win_rvalid`=1 with `win_rdata`=0 in the next cycle.
- R12: A window read to a translation-buffer region returns `win_rvalid`=1 in the next cycle, with `win_rdata` equal to `tlb_rdata` in that cycle. `win_rdata` is 0 whenever `win_rvalid` is 0.
- R13: The register port and the window port act independently, so both can produce their outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | Access size: 0 byte, 1 word, 2 long-word |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid (cycle after request) |
| reg_rdata | output | 32 | Read data |
| reg_err | output | 1 | One-cycle access-error pulse |
| tlb_invalidate | output | 1 | One-cycle invalidate-all pulse |
| tlb_flush | output | 1 | One-cycle flush pulse on address-space change |
| win_valid | input | 1 | Array-window access request |
| win_write | input | 1 | 1 = write, 0 = read |
| win_addr | input | 27 | Window byte address (bits 26:24 region) |
| win_wdata | input | 32 | Window write data |
| win_rvalid | output | 1 | Window read data valid |
| win_rdata | output | 32 | Window read data |
| tlb_req_valid | output | 1 | Forwarded translation-buffer array request |
| tlb_req_write | output | 1 | Direction of forwarded request |
| tlb_req_region | output | 3 | Region code of forwarded request |
| tlb_req_offset | output | 24 | Offset inside the region |
| tlb_req_wdata | output | 32 | Write data of forwarded request |
| tlb_rdata | input | 32 | Read data returned by the translation buffer |

## Verification
Two functions can fall in the same cycle. A register write that raises the invalidate or flush pulse can meet a translation-buffer window access that raises a forward request, and an error on the register port can meet a cache-region read on the window port. The bench drives both ports in the same clock period. Its behavioural model predicts every output of both ports for the following cycle, so a design that serialised the ports or let one side gate the other shows up as a mismatch on either side.

// File: rtl/mmu_ctl_pkg.sv
// Shared types for the MMU control register file.
// Assumes a long-word register grid on the register port and a
// 3-bit region field at the top of the array-window address.
package mmu_ctl_pkg;

    localparam int NUM_REGS = 9;
    localparam logic [1:0] SZ_LONG = 2'd2;

    // Register select; the value is the long-word index of the offset
    typedef enum logic [3:0] {
        RS_CTL    = 4'd0,
        RS_PTEH   = 4'd1,
        RS_PTEL   = 4'd2,
        RS_ASSIST = 4'd3,
        RS_TBASE  = 4'd4,
        RS_FADDR  = 4'd5,
        RS_TRAP   = 4'd6,
        RS_EXC    = 4'd7,
        RS_IRQ    = 4'd8,
        RS_NONE   = 4'd15
    } reg_sel_e;

    // Array-window sub-regions; bit 1 set means a translation-buffer array
    typedef enum logic [2:0] {
        AR_ICACHE_TAG  = 3'd0,
        AR_ICACHE_DATA = 3'd1,
        AR_ITLB_TAG    = 3'd2,
        AR_ITLB_DATA   = 3'd3,
        AR_OCACHE_TAG  = 3'd4,
        AR_OCACHE_DATA = 3'd5,
        AR_UTLB_TAG    = 3'd6,
        AR_UTLB_DATA   = 3'd7
    } arr_region_e;

    function automatic logic is_tlb_region(input logic [2:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/mmu_reg_decode.sv
// Register-port decoder.
// Turns a request into a register select plus read/write enables, or into
// an access error when the size is not long-word, the address is not
// aligned, or the offset is past the last register. Purely combinational.
module mmu_reg_decode
    import mmu_ctl_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          valid,
    input  logic          write,
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel,
    output logic          wr_en,
    output logic          rd_en,
    output logic          acc_err
);

    localparam int IDX_W = AW - 2;

    logic [IDX_W-1:0] idx;
    logic             legal;

    // Classify the request as legal or erroneous
    always_comb begin
        idx   = addr[AW-1:2];
        legal = (size == SZ_LONG) && (addr[1:0] == 2'b00) &&
                (int'(idx) < NUM_REGS);
        sel     = legal ? reg_sel_e'(4'(idx)) : RS_NONE;
        wr_en   = valid &&  write && legal;
        rd_en   = valid && !write && legal;
        acc_err = valid && !legal;
    end

endmodule

// File: rtl/mmu_reg_bank.sv
// Storage and side effects of the control registers.
// Each register keeps only the bits of its keep-mask. A control-word write
// with the invalidate bit set, or a change of the address-space ID, yields
// a one-cycle pulse in the following cycle. Read data and the error flag
// are also registered, one cycle after the request.
// Assumes the decoder never asserts wr_en or rd_en together with acc_err.
module mmu_reg_bank
    import mmu_ctl_pkg::*;
#(
    parameter int DW       = 32,
    parameter int ASID_W   = 8,
    parameter int CODE_W   = 11,
    parameter int ASSIST_W = 4,
    parameter int INV_BIT  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          acc_err,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          inv_pulse,
    output logic          flush_pulse,
    output logic          err_pulse
);

    localparam int CTL_I    = int'(RS_CTL);
    localparam int PTEH_I   = int'(RS_PTEH);
    localparam int ASSIST_I = int'(RS_ASSIST);

    function automatic logic [DW-1:0] keep_mask(input int i);
        logic [DW-1:0] m;
        m = '1;
        case (i)
            int'(RS_CTL):    m[INV_BIT] = 1'b0;
            int'(RS_ASSIST): m = DW'((64'd1 << ASSIST_W) - 64'd1);
            int'(RS_TRAP),
            int'(RS_EXC),
            int'(RS_IRQ):    m = DW'((64'd1 << CODE_W) - 64'd1);
            default:         m = '1;
        endcase
        return m;
    endfunction

    logic [NUM_REGS-1:0][DW-1:0] store;
    logic [DW-1:0]               mask_w [NUM_REGS];
    logic [DW-1:0]               rd_mux;

    // One keep-mask per register, computed from its index
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_mask
        assign mask_w[g] = keep_mask(g);
    end

    // Write the selected register through its keep-mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (sel == reg_sel_e'(i)) store[i] <= wdata & mask_w[i];
            end
        end
    end

    // Select the read value
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == reg_sel_e'(i)) rd_mux = store[i];
        end
    end

    // Register read data, error flag and command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            inv_pulse   <= 1'b0;
            flush_pulse <= 1'b0;
            err_pulse   <= 1'b0;
        end else begin
            rd_valid    <= rd_en;
            rd_data     <= rd_en ? rd_mux : '0;
            inv_pulse   <= wr_en && (sel == RS_CTL) && wdata[INV_BIT];
            flush_pulse <= wr_en && (sel == RS_PTEH) &&
                           (wdata[ASID_W-1:0] != store[PTEH_I][ASID_W-1:0]);
            err_pulse   <= acc_err;
        end
    end

    // R2
    inv_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !store[CTL_I][INV_BIT]);

    // R3
    flush_asid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> store[PTEH_I][ASID_W-1:0] != $past(store[PTEH_I][ASID_W-1:0]));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $stable(store) && !rd_valid && !inv_pulse && !flush_pulse);

    // R4
    assist_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store[ASSIST_I][DW-1:ASSIST_W] == '0);

    // R7
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

endmodule

// File: rtl/mmu_array_window.sv
// Array-access window decoder.
// The top three address bits pick one of eight sub-regions. Translation-
// buffer regions are forwarded one cycle later as a request; cache regions
// are absorbed and read as zero. Read data for forwarded reads comes
// straight from the external buffer in the cycle after the access.
module mmu_array_window
    import mmu_ctl_pkg::*;
#(
    parameter int WIN_AW = 27,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_valid,
    input  logic              win_write,
    input  logic [WIN_AW-1:0] win_addr,
    input  logic [DW-1:0]     win_wdata,
    input  logic [DW-1:0]     tlb_rdata,
    output logic              win_rvalid,
    output logic [DW-1:0]     win_rdata,
    output logic              tlb_req_valid,
    output logic              tlb_req_write,
    output logic [2:0]        tlb_req_region,
    output logic [WIN_AW-4:0] tlb_req_offset,
    output logic [DW-1:0]     tlb_req_wdata
);

    localparam int OFF_W = WIN_AW - 3;

    logic [2:0]       region;
    logic [OFF_W-1:0] offset;
    logic [7:0]       tlb_map;
    logic             hit_tlb;
    logic             rd_tlb_q;

    // Class of each of the eight sub-regions
    for (genvar g = 0; g < 8; g++) begin : g_region
        assign tlb_map[g] = is_tlb_region(3'(g));
    end

    // Split the window address into region code and offset
    always_comb begin
        region  = win_addr[WIN_AW-1 -: 3];
        offset  = win_addr[OFF_W-1:0];
        hit_tlb = tlb_map[region];
    end

    // Register the forwarded request and the read-return flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tlb_req_valid  <= 1'b0;
            tlb_req_write  <= 1'b0;
            tlb_req_region <= '0;
            tlb_req_offset <= '0;
            tlb_req_wdata  <= '0;
            win_rvalid     <= 1'b0;
            rd_tlb_q       <= 1'b0;
        end else begin
            tlb_req_valid  <= win_valid && hit_tlb;
            tlb_req_write  <= win_write;
            tlb_req_region <= region;
            tlb_req_offset <= offset;
            tlb_req_wdata  <= win_wdata;
            win_rvalid     <= win_valid && !win_write;
            rd_tlb_q       <= hit_tlb;
        end
    end

    // Return buffer data for forwarded reads, zero otherwise
    assign win_rdata = (win_rvalid && rd_tlb_q) ? tlb_rdata : '0;

    // R10
    tlb_fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_valid |-> $past(win_valid) && tlb_req_region[1]);

    // R11
    cache_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_addr[WIN_AW-2]) |=> !tlb_req_valid);

    // R12
    win_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_rvalid |-> win_rdata == '0);

endmodule

// File: rtl/mmu_ctl_regs.sv
// MMU control register file, top level.
// Joins the register-port decoder, the register bank with its command
// pulses, and the independent array-window decoder. The two ports share
// no state and may both be active in the same cycle.
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int DW       = 32,
    parameter int AW       = 6,
    parameter int WIN_AW   = 27,
    parameter int ASID_W   = 8,
    parameter int CODE_W   = 11,
    parameter int ASSIST_W = 4,
    parameter int INV_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [1:0]        reg_size,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic              reg_rvalid,
    output logic [DW-1:0]     reg_rdata,
    output logic              reg_err,
    output logic              tlb_invalidate,
    output logic              tlb_flush,
    input  logic              win_valid,
    input  logic              win_write,
    input  logic [WIN_AW-1:0] win_addr,
    input  logic [DW-1:0]     win_wdata,
    output logic              win_rvalid,
    output logic [DW-1:0]     win_rdata,
    output logic              tlb_req_valid,
    output logic              tlb_req_write,
    output logic [2:0]        tlb_req_region,
    output logic [WIN_AW-4:0] tlb_req_offset,
    output logic [DW-1:0]     tlb_req_wdata,
    input  logic [DW-1:0]     tlb_rdata
);

    reg_sel_e sel;
    logic     wr_en;
    logic     rd_en;
    logic     acc_err;

    mmu_reg_decode #(.AW(AW)) u_decode (
        .valid   (reg_valid),
        .write   (reg_write),
        .size    (reg_size),
        .addr    (reg_addr),
        .sel     (sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .acc_err (acc_err)
    );

    mmu_reg_bank #(
        .DW(DW), .ASID_W(ASID_W), .CODE_W(CODE_W),
        .ASSIST_W(ASSIST_W), .INV_BIT(INV_BIT)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .acc_err     (acc_err),
        .sel         (sel),
        .wdata       (reg_wdata),
        .rd_valid    (reg_rvalid),
        .rd_data     (reg_rdata),
        .inv_pulse   (tlb_invalidate),
        .flush_pulse (tlb_flush),
        .err_pulse   (reg_err)
    );

    mmu_array_window #(.WIN_AW(WIN_AW), .DW(DW)) u_window (
        .clk            (clk),
        .rst_n          (rst_n),
        .win_valid      (win_valid),
        .win_write      (win_write),
        .win_addr       (win_addr),
        .win_wdata      (win_wdata),
        .tlb_rdata      (tlb_rdata),
        .win_rvalid     (win_rvalid),
        .win_rdata      (win_rdata),
        .tlb_req_valid  (tlb_req_valid),
        .tlb_req_write  (tlb_req_write),
        .tlb_req_region (tlb_req_region),
        .tlb_req_offset (tlb_req_offset),
        .tlb_req_wdata  (tlb_req_wdata)
    );

    // R1
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tlb_invalidate, tlb_flush, reg_err, reg_rvalid}));

    // R9
    err_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_valid));

endmodule

// File: tb/mmu_ctl_regs_tb.sv
`timescale 1ns/1ps
module mmu_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 0, reg_write = 0;
    logic [1:0]  reg_size = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic        reg_rvalid, reg_err, tlb_invalidate, tlb_flush;
    logic [31:0] reg_rdata;
    logic        win_valid = 0, win_write = 0;
    logic [26:0] win_addr = 0;
    logic [31:0] win_wdata = 0;
    logic        win_rvalid, tlb_req_valid, tlb_req_write;
    logic [31:0] win_rdata, tlb_req_wdata;
    logic [2:0]  tlb_req_region;
    logic [23:0] tlb_req_offset;
    logic [31:0] tlb_rdata = 32'hC0FF_EE11;

    int checks = 0;
    int failures = 0;
    int unsigned mreg [9];

    always #10 clk = ~clk;

    mmu_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_size(reg_size),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .tlb_invalidate(tlb_invalidate), .tlb_flush(tlb_flush),
        .win_valid(win_valid), .win_write(win_write), .win_addr(win_addr),
        .win_wdata(win_wdata), .win_rvalid(win_rvalid), .win_rdata(win_rdata),
        .tlb_req_valid(tlb_req_valid), .tlb_req_write(tlb_req_write),
        .tlb_req_region(tlb_req_region), .tlb_req_offset(tlb_req_offset),
        .tlb_req_wdata(tlb_req_wdata), .tlb_rdata(tlb_rdata)
    );

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // Model predicts next-cycle outputs, clock advances, outputs compared.
    task automatic tick(string tag);
        int   idx;
        bit   legal, tlb;
        bit   e_rv, e_err, e_inv, e_fl, e_tv, e_tw, e_wrv;
        int unsigned e_rd, e_twd, e_wrd;
        logic [2:0]  e_reg;
        logic [23:0] e_off;
        idx   = int'(reg_addr[5:2]);
        legal = (reg_size == 2'd2) && (reg_addr[1:0] == 2'b00) && (idx < 9);
        e_rv  = reg_valid && !reg_write && legal;
        e_rd  = e_rv ? mreg[idx] : 0;
        e_err = reg_valid && !legal;
        e_inv = reg_valid && reg_write && legal && idx == 0 && reg_wdata[2];
        e_fl  = reg_valid && reg_write && legal && idx == 1 &&
                (reg_wdata[7:0] != mreg[1][7:0]);
        if (reg_valid && reg_write && legal) begin
            case (idx)
                0:       mreg[idx] = reg_wdata & ~32'h4;
                3:       mreg[idx] = reg_wdata & 32'hF;
                6, 7, 8: mreg[idx] = reg_wdata & 32'h7FF;
                default: mreg[idx] = reg_wdata;
            endcase
        end
        e_reg = win_addr[26:24];
        tlb   = (e_reg == 3'd2) || (e_reg == 3'd3) || (e_reg == 3'd6) || (e_reg == 3'd7);
        e_tv  = win_valid && tlb;
        e_tw  = win_write;
        e_off = win_addr[23:0];
        e_twd = win_wdata;
        e_wrv = win_valid && !win_write;
        e_wrd = (e_wrv && tlb) ? tlb_rdata : 0;
        @(posedge clk);
        #5;
        chk(tag, "reg_rvalid", 32'(reg_rvalid), 32'(e_rv));
        chk(tag, "reg_rdata", reg_rdata, e_rd);
        chk(tag, "reg_err", 32'(reg_err), 32'(e_err));
        chk(tag, "tlb_invalidate", 32'(tlb_invalidate), 32'(e_inv));
        chk(tag, "tlb_flush", 32'(tlb_flush), 32'(e_fl));
        chk(tag, "tlb_req_valid", 32'(tlb_req_valid), 32'(e_tv));
        if (e_tv) begin
            chk(tag, "tlb_req_write", 32'(tlb_req_write), 32'(e_tw));
            chk(tag, "tlb_req_region", 32'(tlb_req_region), 32'(e_reg));
            chk(tag, "tlb_req_offset", 32'(tlb_req_offset), 32'(e_off));
            if (e_tw) chk(tag, "tlb_req_wdata", tlb_req_wdata, e_twd);
        end
        chk(tag, "win_rvalid", 32'(win_rvalid), 32'(e_wrv));
        chk(tag, "win_rdata", win_rdata, e_wrd);
        reg_valid = 0;
        win_valid = 0;
    endtask

    task automatic reg_set(bit w, logic [1:0] sz, logic [5:0] a, logic [31:0] d);
        reg_valid = 1; reg_write = w; reg_size = sz; reg_addr = a; reg_wdata = d;
    endtask

    task automatic win_set(bit w, logic [26:0] a, logic [31:0] d);
        win_valid = 1; win_write = w; win_addr = a; win_wdata = d;
    endtask

    task automatic rw(bit w, logic [1:0] sz, logic [5:0] a, logic [31:0] d, string tag);
        reg_set(w, sz, a, d);
        tick(tag);
    endtask

    task automatic rd(logic [5:0] a, string tag);
        rw(0, 2'd2, a, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 9; i++) mreg[i] = 0;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        tick("R1");
        for (int i = 0; i < 9; i++) rd(6'(i * 4), "R1");

        // R2 control word and invalidate bit
        rw(1, 2'd2, 6'h00, 32'hFFFF_FFFF, "R2");
        rd(6'h00, "R2");
        rw(1, 2'd2, 6'h00, 32'h0000_0101, "R2");
        rd(6'h00, "R2");
        rw(1, 2'd2, 6'h00, 32'h0000_0004, "R2");
        rd(6'h00, "R2");

        // R3 address-space ID flush
        rw(1, 2'd2, 6'h04, 32'h1234_5600, "R3");
        rw(1, 2'd2, 6'h04, 32'h1234_5678, "R3");
        rw(1, 2'd2, 6'h04, 32'hABCD_EF78, "R3");
        rw(1, 2'd2, 6'h04, 32'hABCD_EF79, "R3");
        rd(6'h04, "R3");

        // R4 / R5 / R6 masks
        rw(1, 2'd2, 6'h0C, 32'hFFFF_FFFF, "R4");
        rd(6'h0C, "R4");
        rw(1, 2'd2, 6'h18, 32'hFFFF_FFFF, "R5");
        rw(1, 2'd2, 6'h1C, 32'hA5A5_A5A5, "R5");
        rw(1, 2'd2, 6'h20, 32'h0000_0FFF, "R5");
        rd(6'h18, "R5"); rd(6'h1C, "R5"); rd(6'h20, "R5");
        rw(1, 2'd2, 6'h08, 32'hDEAD_BEEF, "R6");
        rw(1, 2'd2, 6'h10, 32'h8000_0001, "R6");
        rw(1, 2'd2, 6'h14, 32'h7FFF_FFFE, "R6");
        rd(6'h08, "R6"); rd(6'h10, "R6"); rd(6'h14, "R6");

        // R7 back-to-back write then read
        rw(1, 2'd2, 6'h08, 32'h0BAD_F00D, "R7");
        rd(6'h08, "R7");
        rd(6'h14, "R7");

        // R8 illegal sizes and alignment; state must stay
        rw(1, 2'd0, 6'h04, 32'h0000_0011, "R8");
        rw(1, 2'd1, 6'h00, 32'h0000_0004, "R8");
        rw(1, 2'd3, 6'h0C, 32'h0000_0003, "R8");
        rw(1, 2'd2, 6'h05, 32'h0000_0022, "R8");
        rw(0, 2'd1, 6'h08, 32'h0, "R8");
        rd(6'h04, "R8"); rd(6'h00, "R8"); rd(6'h0C, "R8");

        // R9 undefined offsets
        rw(1, 2'd2, 6'h24, 32'hFFFF_FFFF, "R9");
        rw(0, 2'd2, 6'h3C, 32'h0, "R9");
        for (int i = 0; i < 9; i++) rd(6'(i * 4), "R9");

        // R10 / R11 / R12 all eight window regions
        for (int r = 0; r < 8; r++) begin
            win_set(1, {3'(r), 24'h00AB_C0}, 32'h1000_0000 + r);
            tick((r % 4) >= 2 ? "R10" : "R11");
            win_set(0, {3'(r), 24'hFF_FFFC}, 32'h0);
            tick((r % 4) >= 2 ? "R12" : "R11");
        end

        // R13 both ports in the same cycle
        reg_set(1, 2'd2, 6'h00, 32'h0000_0004);
        win_set(1, {3'd6, 24'h12_3450}, 32'hCAFE_0006);
        tick("R13");
        reg_set(1, 2'd2, 6'h04, 32'h0000_0042);
        win_set(0, {3'd3, 24'h00_0010}, 32'h0);
        tick("R13");
        reg_set(1, 2'd0, 6'h04, 32'h0000_0099);
        win_set(0, {3'd5, 24'h00_0020}, 32'h0);
        tick("R13");
        reg_set(0, 2'd2, 6'h04, 32'h0);
        win_set(1, {3'd1, 24'h00_0030}, 32'h5555_AAAA);
        tick("R13");

        tick("R1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule